// File: doc/BRIEF.md
# Selectable-Law PCM Compander

This block converts linear voice samples to and from 8-bit companded bytes for a single 64 kb/s voice channel, which carries one byte in each direction per 8 kHz sample period. A 16-bit two's-complement sample offered with an encode strobe becomes one byte. A received byte offered with a decode strobe becomes a 16-bit signed sample placed at the midpoint of its quantization interval. The companding follows the G.711 segment laws, with eight segments for each polarity.

A two-bit selector chooses the byte coding at run time. The choices are A-law with even-bit inversion, µ-law with inverted magnitude, and plain sign-magnitude on the µ-law segments. The selector is only taken in at a sample boundary, which is a cycle with the encode strobe high. Decodes that arrive between strobes use the coding captured at the last boundary. Filtering, gain and serial framing are handled by neighbouring blocks.

Top module: `pcm_compander`

## Requirements
- R1: While `rst_n` is low, both valid outputs are 0, `enc_byte_o` is 8'h00 and `dec_sample_o` is 16'h0000.
- R2: A strobe on `enc_valid_i` or `dec_valid_i` at clock edge N raises the matching valid output for exactly the cycle after edge N, with the result present in that cycle. Without a strobe, the valid output is 0 and the data output keeps its last value.
- R3: µ-law encode (selector 2'b00). Take the 14-bit value `sample>>>2`. Its magnitude is the negation for negative values. Clamp the magnitude to 8158 and add 33. The segment is the position of the highest set bit minus 5. The step is bits [seg+4:seg+1]. The byte is {sign, ~seg, ~step}, where sign is 1 for a non-negative sample.
- R4: A-law encode (selector 2'b01). Take the 13-bit value `sample>>>3`. Its magnitude is the value itself when non-negative and its bitwise complement when negative. Below 32, the segment is 0 and the step is magnitude bits [4:1]. Otherwise the segment is the position of the highest set bit minus 4 and the step is bits [seg+3:seg]. The byte is {sign, seg, step} XOR 8'h55, where sign is 1 for a non-negative sample.
- R5: Sign-magnitude encode (selector 2'b10). Bit 7 is the sign (1 for a non-negative sample), bits 6:4 are the µ-law segment and bits 3:0 are the µ-law step, none of them inverted. The result equals the µ-law byte XOR 8'h7F.
- R6: Encoding never wraps. A µ-law magnitude of 8158 or more gives the largest code: 8'h80 for positive samples and 8'h00 for negative ones (8'hFF and 8'h7F in sign-magnitude). Full-scale A-law samples give 8'hAA and 8'h2A.
- R7: µ-law decode. Let u = ~byte and t = (u[3:0]*8 + 132) << u[6:4]. The output is 132 - t when u[7] is 1, and t - 132 otherwise.
- R8: A-law decode. Let a = byte XOR 8'h55. For segment a[6:4] = 0, t = a[3:0]*16 + 8. Otherwise t = (a[3:0]*16 + 264) << (a[6:4]-1). The output is t when a[7] is 1, and -t otherwise.
- R9: Sign-magnitude decode gives the µ-law decode of byte XOR 8'h7F.
- R10: Selector codes: 2'b00 µ-law, 2'b01 A-law, 2'b10 sign-magnitude, 2'b11 µ-law. After reset the active coding is µ-law.
- R11: The active coding is loaded from the selector only in a cycle where `enc_valid_i` is high, and that cycle's conversions already use the new coding. In every other cycle, decodes use the held coding, whatever the selector shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| law_sel | input | 2 | Requested byte coding |
| enc_valid_i | input | 1 | Encode strobe; also marks a sample boundary |
| enc_sample_i | input | 16 | Linear two's-complement sample to encode |
| enc_valid_o | output | 1 | Encoded byte valid |
| enc_byte_o | output | 8 | Companded byte |
| dec_valid_i | input | 1 | Decode strobe |
| dec_byte_i | input | 8 | Companded byte to decode |
| dec_valid_o | output | 1 | Decoded sample valid |
| dec_sample_o | output | 16 | Linear two's-complement decoded sample |

## Verification
The bench sweeps the whole input range in every coding and decodes all 256 codes per coding. This catches a segment found one bit off, which would show up as bytes wrong at every power-of-two edge, and a misplaced inversion mask, which would corrupt every byte of one coding. Full-scale inputs of both polarities are used to expose a missing clamp, which would wrap the loudest µ-law samples into quiet codes. The bench also changes the selector between strobes, and separately sends a decode in the same cycle as a boundary. A design that followed the selector at once would decode with the wrong law in the first case, and one that lagged a cycle would do so in the second. The reserved selector code and the coding in force straight after reset are checked as well.

// File: rtl/pcm_law_pkg.sv
package pcm_law_pkg;

  localparam int SAMPLE_W = 16;
  localparam int CODE_W   = 8;
  localparam int SEG_W    = 3;
  localparam int STEP_W   = 4;
  localparam int MU_MAG_W = SAMPLE_W - 2;
  localparam int A_MAG_W  = SAMPLE_W - 4;
  localparam int MU_BIAS  = 33;
  localparam int MU_CLIP  = 8158;
  localparam int A_SEG1   = 32;

  typedef enum logic [1:0] {
    LAW_MU     = 2'b00,
    LAW_A      = 2'b01,
    LAW_SM     = 2'b10,
    LAW_MU_ALT = 2'b11
  } law_e;

  localparam logic [CODE_W-1:0] A_EVEN_MASK = 8'h55;
  localparam logic [CODE_W-1:0] SM_MASK     = 8'h7F;

  function automatic law_e law_norm(input logic [1:0] raw);
    law_e r;
    case (raw)
      2'b01:   r = LAW_A;
      2'b10:   r = LAW_SM;
      default: r = LAW_MU;
    endcase
    return r;
  endfunction

  function automatic logic [CODE_W-1:0] mu_encode(input logic [SAMPLE_W-1:0] s);
    logic                neg;
    logic [MU_MAG_W-1:0] x;
    logic [MU_MAG_W:0]   mag;
    logic [MU_MAG_W-2:0] biased;
    logic [MU_MAG_W-2:0] sh;
    logic [SEG_W-1:0]    seg;
    neg = s[SAMPLE_W-1];
    x   = s[SAMPLE_W-1:2];
    mag = neg ? ((MU_MAG_W+1)'(0) - {x[MU_MAG_W-1], x}) : {1'b0, x};
    if (mag > (MU_MAG_W+1)'(MU_CLIP)) mag = (MU_MAG_W+1)'(MU_CLIP);
    biased = (MU_MAG_W-1)'(mag + (MU_MAG_W+1)'(MU_BIAS));
    seg = '0;
    for (int p = 5; p < MU_MAG_W - 1; p++) begin
      if (biased[p]) seg = SEG_W'(p - 5);
    end
    sh = biased >> ({1'b0, seg} + 4'd1);
    return {~neg, ~seg, ~sh[STEP_W-1:0]};
  endfunction

  function automatic logic [CODE_W-1:0] a_encode(input logic [SAMPLE_W-1:0] s);
    logic               neg;
    logic [A_MAG_W:0]   x;
    logic [A_MAG_W-1:0] mag;
    logic [A_MAG_W-1:0] sh;
    logic [SEG_W-1:0]   seg;
    logic [STEP_W-1:0]  step;
    neg = s[SAMPLE_W-1];
    x   = s[SAMPLE_W-1:3];
    mag = neg ? ~x[A_MAG_W-1:0] : x[A_MAG_W-1:0];
    seg = '0;
    if (mag < A_MAG_W'(A_SEG1)) begin
      step = mag[4:1];
    end else begin
      for (int p = 5; p < A_MAG_W; p++) begin
        if (mag[p]) seg = SEG_W'(p - 4);
      end
      sh   = mag >> seg;
      step = sh[STEP_W-1:0];
    end
    return {~neg, seg, step} ^ A_EVEN_MASK;
  endfunction

  function automatic logic [SAMPLE_W-1:0] mu_decode(input logic [CODE_W-1:0] b);
    logic [CODE_W-1:0]   u;
    logic [SAMPLE_W-1:0] t;
    u = ~b;
    t = ({12'd0, u[3:0]} << 3) + SAMPLE_W'(4 * MU_BIAS);
    t = t << u[6:4];
    return u[7] ? (SAMPLE_W'(4 * MU_BIAS) - t) : (t - SAMPLE_W'(4 * MU_BIAS));
  endfunction

  function automatic logic [SAMPLE_W-1:0] a_decode(input logic [CODE_W-1:0] b);
    logic [CODE_W-1:0]   a;
    logic [SAMPLE_W-1:0] base;
    logic [SAMPLE_W-1:0] t;
    a    = b ^ A_EVEN_MASK;
    base = {12'd0, a[3:0]} << 4;
    if (a[6:4] == 3'd0) t = base + 16'd8;
    else                t = (base + 16'd264) << (a[6:4] - 3'd1);
    return a[7] ? t : (SAMPLE_W'(0) - t);
  endfunction

endpackage

// File: rtl/pcm_mode_ctl.sv
module pcm_mode_ctl
  import pcm_law_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] law_sel,
  input  logic       boundary,
  output law_e       mode_eff,
  output law_e       mode_q
);

  law_e req;

  always_comb begin
    req      = law_norm(law_sel);
    mode_eff = boundary ? req : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= LAW_MU;
    else if (boundary) mode_q <= req;
  end

endmodule

// File: rtl/pcm_encoder.sv
module pcm_encoder
  import pcm_law_pkg::*;
#(
  parameter int SW = SAMPLE_W,
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  law_e          mode,
  input  logic          valid_i,
  input  logic [SW-1:0] sample_i,
  output logic          valid_o,
  output logic [CW-1:0] byte_o
);

  logic [CW-1:0] code_mu;
  logic [CW-1:0] code_a;
  logic [CW-1:0] code_sel;

  always_comb begin
    code_mu = mu_encode(sample_i);
    code_a  = a_encode(sample_i);
    case (mode)
      LAW_A:   code_sel = code_a;
      LAW_SM:  code_sel = code_mu ^ SM_MASK;
      default: code_sel = code_mu;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      byte_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) byte_o <= code_sel;
    end
  end

endmodule

// File: rtl/pcm_decoder.sv
module pcm_decoder
  import pcm_law_pkg::*;
#(
  parameter int SW = SAMPLE_W,
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  law_e          mode,
  input  logic          valid_i,
  input  logic [CW-1:0] byte_i,
  output logic          valid_o,
  output logic [SW-1:0] sample_o
);

  logic [CW-1:0] mu_in;
  logic [SW-1:0] lin_sel;

  always_comb begin
    mu_in = (mode == LAW_SM) ? (byte_i ^ SM_MASK) : byte_i;
    if (mode == LAW_A) lin_sel = a_decode(byte_i);
    else               lin_sel = mu_decode(mu_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      sample_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) sample_o <= lin_sel;
    end
  end

endmodule

// File: rtl/pcm_compander.sv
module pcm_compander
  import pcm_law_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  law_sel,
  input  logic        enc_valid_i,
  input  logic [15:0] enc_sample_i,
  output logic        enc_valid_o,
  output logic [7:0]  enc_byte_o,
  input  logic        dec_valid_i,
  input  logic [7:0]  dec_byte_i,
  output logic        dec_valid_o,
  output logic [15:0] dec_sample_o
);

  logic sample_boundary;
  law_e mode_eff;
  law_e mode_q;

  assign sample_boundary = enc_valid_i;

  pcm_mode_ctl i_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .law_sel  (law_sel),
    .boundary (sample_boundary),
    .mode_eff (mode_eff),
    .mode_q   (mode_q)
  );

  pcm_encoder #(.SW(SAMPLE_W), .CW(CODE_W)) i_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_eff),
    .valid_i  (enc_valid_i),
    .sample_i (enc_sample_i),
    .valid_o  (enc_valid_o),
    .byte_o   (enc_byte_o)
  );

  pcm_decoder #(.SW(SAMPLE_W), .CW(CODE_W)) i_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_eff),
    .valid_i  (dec_valid_i),
    .byte_i   (dec_byte_i),
    .valid_o  (dec_valid_o),
    .sample_o (dec_sample_o)
  );

endmodule

// File: rtl/pcm_compander_chk.sv
module pcm_compander_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  law_sel,
  input logic        enc_valid_i,
  input logic [15:0] enc_sample_i,
  input logic        enc_valid_o,
  input logic [7:0]  enc_byte_o,
  input logic        dec_valid_i,
  input logic [7:0]  dec_byte_i,
  input logic        dec_valid_o,
  input logic [15:0] dec_sample_o,
  input logic        sample_boundary,
  input logic [1:0]  mode_q
);

  // R2
  enc_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid_i |=> enc_valid_o);

  // R2
  enc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_valid_i |=> (!enc_valid_o && $stable(enc_byte_o)));

  // R2
  dec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_i |=> (!dec_valid_o && $stable(dec_sample_o)));

  // R3
  enc_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid_i |=> (enc_byte_o[7] == !$past(enc_sample_i[15])));

  // R6
  mu_clamp_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_valid_i && law_sel == 2'b00 && $signed(enc_sample_i) >= 16'sd32632)
      |=> enc_byte_o == 8'h80);

  // R6
  mu_clamp_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_valid_i && law_sel == 2'b00 && $signed(enc_sample_i) <= -16'sd32636)
      |=> enc_byte_o == 8'h00);

  // R7
  dec_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_i && dec_byte_i[7]) |=> !dec_sample_o[15]);

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_boundary |=> $stable(mode_q));

  // R11
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_boundary && law_sel == 2'b01) |=> mode_q == 2'b01);

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_state_chk: assert (!enc_valid_o && !dec_valid_o);
    end
  end

endmodule

bind pcm_compander pcm_compander_chk i_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .law_sel         (law_sel),
  .enc_valid_i     (enc_valid_i),
  .enc_sample_i    (enc_sample_i),
  .enc_valid_o     (enc_valid_o),
  .enc_byte_o      (enc_byte_o),
  .dec_valid_i     (dec_valid_i),
  .dec_byte_i      (dec_byte_i),
  .dec_valid_o     (dec_valid_o),
  .dec_sample_o    (dec_sample_o),
  .sample_boundary (sample_boundary),
  .mode_q          (mode_q)
);

// File: tb/test_pcm_compander.sv
module test_pcm_compander;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  law_sel = 2'b00;
  logic        enc_valid_i = 1'b0;
  logic [15:0] enc_sample_i = '0;
  logic        enc_valid_o;
  logic [7:0]  enc_byte_o;
  logic        dec_valid_i = 1'b0;
  logic [7:0]  dec_byte_i = '0;
  logic        dec_valid_o;
  logic [15:0] dec_sample_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_compander i_pcm_compander (
    .clk          (clk),
    .rst_n        (rst_n),
    .law_sel      (law_sel),
    .enc_valid_i  (enc_valid_i),
    .enc_sample_i (enc_sample_i),
    .enc_valid_o  (enc_valid_o),
    .enc_byte_o   (enc_byte_o),
    .dec_valid_i  (dec_valid_i),
    .dec_byte_i   (dec_byte_i),
    .dec_valid_o  (dec_valid_o),
    .dec_sample_o (dec_sample_o)
  );

  // ---------------- independent reference models ----------------
  function automatic int ref_mu_enc(input int s);
    int x = s >>> 2;
    int mask;
    int seg;
    if (x < 0) begin x = -x; mask = 'h7F; end else mask = 'hFF;
    if (x > 8159) x = 8159;
    x = x + 33;
    for (seg = 0; seg < 8; seg++) if (x <= ((64 << seg) - 1)) break;
    if (seg >= 8) return 'h7F ^ mask;
    return (((seg << 4) | ((x >> (seg + 1)) & 15)) ^ mask) & 'hFF;
  endfunction

  function automatic int ref_a_enc(input int s);
    int x = s >>> 3;
    int mask;
    int seg;
    int aval;
    if (x >= 0) mask = 'hD5; else begin mask = 'h55; x = -x - 1; end
    for (seg = 0; seg < 8; seg++) if (x <= ((32 << seg) - 1)) break;
    if (seg >= 8) return 'h7F ^ mask;
    aval = seg << 4;
    if (seg < 2) aval = aval | ((x >> 1) & 15);
    else         aval = aval | ((x >> seg) & 15);
    return (aval ^ mask) & 'hFF;
  endfunction

  function automatic int ref_sm_enc(input int s);
    return ref_mu_enc(s) ^ 'h7F;
  endfunction

  function automatic int ref_mu_dec(input int b);
    int u = (~b) & 'hFF;
    int t = (((u & 15) * 8) + 132) * (1 << ((u >> 4) & 7));
    return ((u & 'h80) != 0) ? (132 - t) : (t - 132);
  endfunction

  function automatic int ref_a_dec(input int b);
    int a = b ^ 'h55;
    int seg = (a >> 4) & 7;
    int t = (a & 15) * 16;
    if (seg == 0) t = t + 8;
    else          t = (t + 264) * (1 << (seg - 1));
    return ((a & 'h80) != 0) ? t : -t;
  endfunction

  function automatic int ref_enc(input int law, input int s);
    if (law == 1) return ref_a_enc(s);
    if (law == 2) return ref_sm_enc(s);
    return ref_mu_enc(s);
  endfunction

  function automatic int ref_dec(input int law, input int b);
    if (law == 1) return ref_a_dec(b);
    if (law == 2) return ref_mu_dec(b ^ 'h7F);
    return ref_mu_dec(b);
  endfunction

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one conversion cycle; on return, the results of that cycle are on the outputs
  task automatic cycle(input bit ev, input int s, input bit dv, input int b, input int law);
    @(negedge clk);
    law_sel      = 2'(law);
    enc_valid_i  = ev;
    enc_sample_i = 16'(s);
    dec_valid_i  = dv;
    dec_byte_i   = 8'(b);
    @(negedge clk);
    enc_valid_i = 1'b0;
    dec_valid_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(enc_valid_o == 1'b0, "R1 enc_valid_o", int'(enc_valid_o), 0);
    check(dec_valid_o == 1'b0, "R1 dec_valid_o", int'(dec_valid_o), 0);
    check(enc_byte_o == 8'h00, "R1 enc_byte_o", int'(enc_byte_o), 0);
    check(dec_sample_o == 16'h0000, "R1 dec_sample_o", int'(dec_sample_o), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_mode();
    do_reset();
    // decode only, selector asking A-law: held coding must be µ-law (R10)
    cycle(1'b0, 0, 1'b1, 'h00, 1);
    check($signed(dec_sample_o) == ref_mu_dec('h00), "R10 reset law",
          int'($signed(dec_sample_o)), ref_mu_dec('h00));
  endtask

  task automatic t_enc_sweep(input int law, input string req);
    cycle(1'b1, 0, 1'b0, 0, law);
    for (int s = -32768; s < 32768; s += 61) begin
      cycle(1'b1, s, 1'b0, 0, law);
      check(enc_byte_o == 8'(ref_enc(law, s)), req, int'(enc_byte_o), ref_enc(law, s));
    end
    for (int k = 0; k < 13; k++) begin
      int s = (1 << k) + 2;
      cycle(1'b1, s, 1'b0, 0, law);
      check(enc_byte_o == 8'(ref_enc(law, s)), req, int'(enc_byte_o), ref_enc(law, s));
      cycle(1'b1, -s, 1'b0, 0, law);
      check(enc_byte_o == 8'(ref_enc(law, -s)), req, int'(enc_byte_o), ref_enc(law, -s));
    end
  endtask

  task automatic t_clamp();
    int vals[4] = '{32767, -32768, 32640, -32640};
    for (int law = 0; law < 3; law++) begin
      foreach (vals[i]) begin
        cycle(1'b1, vals[i], 1'b0, 0, law);
        check(enc_byte_o == 8'(ref_enc(law, vals[i])), "R6 clamp",
              int'(enc_byte_o), ref_enc(law, vals[i]));
      end
    end
    cycle(1'b1, 32767, 1'b0, 0, 0);
    check(enc_byte_o == 8'h80, "R6 mu max pos", int'(enc_byte_o), 'h80);
    cycle(1'b1, -32768, 1'b0, 0, 2);
    check(enc_byte_o == 8'h7F, "R6 sm max neg", int'(enc_byte_o), 'h7F);
  endtask

  task automatic t_dec_all(input int law, input string req);
    cycle(1'b1, 0, 1'b0, 0, law);
    for (int b = 0; b < 256; b++) begin
      cycle(1'b0, 0, 1'b1, b, law);
      check($signed(dec_sample_o) == ref_dec(law, b), req,
            int'($signed(dec_sample_o)), ref_dec(law, b));
    end
  endtask

  task automatic t_latency_hold();
    cycle(1'b1, 12345, 1'b1, 'h3C, 1);
    check(enc_valid_o == 1'b1, "R2 enc valid after one cycle", int'(enc_valid_o), 1);
    check(dec_valid_o == 1'b1, "R2 dec valid after one cycle", int'(dec_valid_o), 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(enc_valid_o == 1'b0, "R2 enc valid drops", int'(enc_valid_o), 0);
      check(dec_valid_o == 1'b0, "R2 dec valid drops", int'(dec_valid_o), 0);
      check(enc_byte_o == 8'(ref_a_enc(12345)), "R2 enc hold",
            int'(enc_byte_o), ref_a_enc(12345));
      check($signed(dec_sample_o) == ref_a_dec('h3C), "R2 dec hold",
            int'($signed(dec_sample_o)), ref_a_dec('h3C));
    end
  endtask

  task automatic t_reserved_code();
    cycle(1'b1, 5000, 1'b0, 0, 3);
    check(enc_byte_o == 8'(ref_mu_enc(5000)), "R10 code 3 encodes mu",
          int'(enc_byte_o), ref_mu_enc(5000));
    cycle(1'b0, 0, 1'b1, 'h15, 1);
    check($signed(dec_sample_o) == ref_mu_dec('h15), "R10 code 3 held as mu",
          int'($signed(dec_sample_o)), ref_mu_dec('h15));
  endtask

  task automatic t_boundary();
    cycle(1'b1, 1000, 1'b0, 0, 1);
    // selector moved without a boundary: A-law stays in force (R11)
    cycle(1'b0, 0, 1'b1, 'hD5, 2);
    check($signed(dec_sample_o) == ref_a_dec('hD5), "R11 held law",
          int'($signed(dec_sample_o)), ref_a_dec('hD5));
    // boundary with decode in the same cycle: new law applies at once
    cycle(1'b1, -777, 1'b1, 'hD5, 2);
    check($signed(dec_sample_o) == ref_dec(2, 'hD5), "R11 same-cycle law dec",
          int'($signed(dec_sample_o)), ref_dec(2, 'hD5));
    check(enc_byte_o == 8'(ref_sm_enc(-777)), "R11 same-cycle law enc",
          int'(enc_byte_o), ref_sm_enc(-777));
    cycle(1'b0, 0, 1'b1, 'h91, 1);
    check($signed(dec_sample_o) == ref_dec(2, 'h91), "R11 sm held",
          int'($signed(dec_sample_o)), ref_dec(2, 'h91));
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
    report();
  end

  initial begin
    t_reset();
    t_reset_mode();
    t_enc_sweep(0, "R3 mu encode");
    t_enc_sweep(1, "R4 A encode");
    t_enc_sweep(2, "R5 sm encode");
    t_clamp();
    t_dec_all(0, "R7 mu decode");
    t_dec_all(1, "R8 A decode");
    t_dec_all(2, "R9 sm decode");
    t_latency_hold();
    t_reserved_code();
    t_boundary();
    report();
  end

endmodule